// File: doc/BRIEF.md
# Depth skip predictor

This block builds the four skip-style intra predictions used for flat regions of a depth map. For a square coding unit of 8, 16, 32 or 64 samples on a side, it fills the block from the column of samples to its left and the row of samples above it. Two of the modes copy a single neighbour into every position. The other two copy the neighbours along rows or along columns. The block emits one predicted line per clock and runs the four modes back to back. Each line goes out on the prediction port, where an external metric unit compares it with the original block.

The metric unit returns one distortion value per mode. Once the block holds all four values, it picks the mode with the lowest value. It does not keep the candidate predictions in storage. Instead it generates the winning prediction a second time, and during that second pass the environment presents the matching original line. The block subtracts each regenerated line from its original line to give a signed residue line. A one-cycle done pulse closes the run.

Top module: `depth_skip_pred`

## Requirements
- R1: `size_sel` codes 0, 1, 2 and 3 select block sizes N = 8, 16, 32 and 64. Samples are 8 bits wide. Neighbour i and lane c sit at bits [8i+7:8i] of their vector. All of these are captured on the clock edge where `start` is accepted.
- R2: Mode 0 (flat-left) fills every sample with left neighbour N/2.
- R3: Mode 1 (row-copy) fills every sample of row r with left neighbour r.
- R4: Mode 2 (flat-top) fills every sample with above neighbour N/2.
- R5: Mode 3 (column-copy) fills every sample of column c with above neighbour c.
- R6: The candidate lines appear in mode order 0, 1, 2, 3, with rows 0 to N-1 within each mode. They fill 4N consecutive cycles, starting the cycle after `start` is accepted. Each line has `pred_valid` high, `pred_regen` low, and `pred_mode` and `pred_row` identifying it.
- R7: While candidates are generated or the block waits for distortions, `dist_valid` pulses load the distortions of modes 0, 1, 2, 3 in that order. Any further pulses before the next run are ignored.
- R8: The chosen mode is the one with the smallest distortion, and on equal values the lower mode index wins. `best_mode` shows it from the first regenerated line and holds it until the next run chooses again.
- R9: The block regenerates the chosen prediction as N consecutive lines flagged by `pred_regen`. The first of these appears two cycles after the edge that captures the fourth distortion, or two cycles after the last candidate line if that is later.
- R10: Each residue lane is the 9-bit two's-complement value original minus predicted, at bits [9c+8:9c]. The original line is sampled on the edge that follows the regenerated line's appearance, and the residue appears with `res_valid` one cycle after that line.
- R11: Lanes at or above N are zero on both `pred_line` and `res_line`.
- R12: `done` pulses for one cycle, in the cycle after the last residue line.
- R13: A `start` that arrives during a run (from acceptance to the last regenerated line) is ignored.
- R14: After reset, `pred_valid`, `res_valid` and `done` are low, `pred_line` is zero and `best_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| size_sel | input | 2 | Block size code, N = 8 << code |
| left_nb | input | 512 | Left neighbour samples, 8 bits each |
| above_nb | input | 512 | Above neighbour samples, 8 bits each |
| dist_valid | input | 1 | Distortion strobe from the metric unit |
| dist_in | input | 16 | Distortion value for the next mode |
| orig_line | input | 512 | Original line matching the shown regenerated row |
| pred_valid | output | 1 | Predicted line valid |
| pred_regen | output | 1 | Line belongs to the regeneration pass |
| pred_mode | output | 2 | Mode of the shown line |
| pred_row | output | 6 | Row index of the shown line |
| pred_line | output | 512 | Predicted line, 8 bits per lane |
| res_valid | output | 1 | Residue line valid |
| res_line | output | 576 | Residue line, 9-bit signed per lane |
| best_mode | output | 2 | Chosen mode |
| done | output | 1 | Run complete pulse |

## Verification
A corrupted row or mode counter shows up in the very next predicted line, as a wrong row index or as a line whose contents belong to another row or mode. A fault in the distortion registers or the comparator stays hidden through the whole candidate phase. It only appears when the regeneration pass begins, as a wrong `best_mode` and wrong regenerated lines and residues. A stale size register or lane mask shows up as nonzero upper lanes on the first line of a run. Pipeline faults move `res_valid` or `done` by a cycle, and that is visible at the first residue.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [1:0] {
    MODE_FLAT_LEFT = 2'd0,
    MODE_ROW_COPY  = 2'd1,
    MODE_FLAT_TOP  = 2'd2,
    MODE_COL_COPY  = 2'd3
  } dsk_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GEN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REGEN = 2'd3
  } dsk_state_e;

  localparam int NUM_MODES = 4;
endpackage

// File: rtl/dsk_line_gen.sv
module dsk_line_gen
  import dsk_pkg::*;
#(
  parameter int MAX_N = 64,
  parameter int SW    = 8,
  localparam int ROW_W = $clog2(MAX_N),
  localparam int NW    = ROW_W + 1
) (
  input  logic [MAX_N*SW-1:0] left_q,
  input  logic [MAX_N*SW-1:0] above_q,
  input  logic [NW-1:0]       n_sz,
  input  logic [1:0]          mode,
  input  logic [ROW_W-1:0]    row,
  output logic [MAX_N*SW-1:0] line
);
  logic [NW-1:0] half;
  logic [SW-1:0] left_mid, above_mid, left_row;

  assign half      = n_sz >> 1;
  assign left_mid  = left_q[half*SW +: SW];
  assign above_mid = above_q[half*SW +: SW];
  assign left_row  = left_q[row*SW +: SW];

  for (genvar c = 0; c < MAX_N; c++) begin : g_lane
    always_comb begin
      if (NW'(c) < n_sz) begin
        unique case (dsk_mode_e'(mode))
          MODE_FLAT_LEFT: line[c*SW +: SW] = left_mid;
          MODE_ROW_COPY:  line[c*SW +: SW] = left_row;
          MODE_FLAT_TOP:  line[c*SW +: SW] = above_mid;
          default:        line[c*SW +: SW] = above_q[c*SW +: SW];
        endcase
      end else begin
        line[c*SW +: SW] = '0;
      end
    end
  end
endmodule

// File: rtl/dsk_pick.sv
module dsk_pick #(
  parameter int DIST_W = 16
) (
  input  logic [4*DIST_W-1:0] dist_flat,
  output logic [1:0]          best
);
  logic [DIST_W-1:0] d0, d1, d2, d3, v01, v23;
  logic [1:0]        w01, w23;

  assign d0 = dist_flat[0*DIST_W +: DIST_W];
  assign d1 = dist_flat[1*DIST_W +: DIST_W];
  assign d2 = dist_flat[2*DIST_W +: DIST_W];
  assign d3 = dist_flat[3*DIST_W +: DIST_W];

  // strict less-than at each node keeps the lower index on ties
  always_comb begin
    if (d1 < d0) begin w01 = 2'd1; v01 = d1; end
    else         begin w01 = 2'd0; v01 = d0; end
    if (d3 < d2) begin w23 = 2'd3; v23 = d3; end
    else         begin w23 = 2'd2; v23 = d2; end
    best = (v23 < v01) ? w23 : w01;
  end
endmodule

// File: rtl/dsk_residue.sv
module dsk_residue #(
  parameter int MAX_N = 64,
  parameter int SW    = 8,
  parameter int RW    = 9,
  localparam int NW   = $clog2(MAX_N) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_last,
  input  logic [NW-1:0]       n_sz,
  input  logic [MAX_N*SW-1:0] pred,
  input  logic [MAX_N*SW-1:0] orig,
  output logic                res_valid,
  output logic                res_last,
  output logic [MAX_N*RW-1:0] res
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_last  <= 1'b0;
    end else begin
      res_valid <= in_valid;
      res_last  <= in_valid & in_last;
    end
  end

  for (genvar c = 0; c < MAX_N; c++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        res[c*RW +: RW] <= '0;
      end else if (in_valid && (NW'(c) < n_sz)) begin
        res[c*RW +: RW] <= RW'({1'b0, orig[c*SW +: SW]}) - RW'({1'b0, pred[c*SW +: SW]});
      end else begin
        res[c*RW +: RW] <= '0;
      end
    end
  end
endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
  import dsk_pkg::*;
#(
  parameter int MAX_N  = 64,
  parameter int MIN_N  = 8,
  parameter int DIST_W = 16,
  localparam int ROW_W = $clog2(MAX_N),
  localparam int NW    = ROW_W + 1,
  localparam int CNT_W = $clog2(NUM_MODES) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          size_sel,
  input  logic                dist_valid,
  input  logic [DIST_W-1:0]   dist_in,
  output logic                cap_en,
  output logic [NW-1:0]       n_q,
  output logic [1:0]          mode_q,
  output logic [ROW_W-1:0]    row_q,
  output logic                emit,
  output logic                regen,
  output logic                last_row,
  output logic                pick_en,
  output logic [4*DIST_W-1:0] dist_flat
);
  dsk_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIST_W-1:0] dist_r [NUM_MODES];
  logic              all_dist;
  logic              dist_take;

  assign all_dist  = (cnt_q == CNT_W'(NUM_MODES));
  assign cap_en    = (st_q == ST_IDLE) && start;
  assign emit      = (st_q == ST_GEN) || (st_q == ST_REGEN);
  assign regen     = (st_q == ST_REGEN);
  assign last_row  = ({1'b0, row_q} == (n_q - 1'b1));
  assign pick_en   = (st_q == ST_WAIT) && all_dist;
  assign dist_take = dist_valid && !all_dist && ((st_q == ST_GEN) || (st_q == ST_WAIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      n_q    <= NW'(MIN_N);
      mode_q <= 2'd0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (dist_take) cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            n_q    <= NW'(MIN_N) << size_sel;
            mode_q <= 2'd0;
            row_q  <= '0;
            cnt_q  <= '0;
            st_q   <= ST_GEN;
          end
        end
        ST_GEN: begin
          if (last_row) begin
            row_q <= '0;
            if (mode_q == 2'(NUM_MODES - 1)) st_q <= ST_WAIT;
            else mode_q <= mode_q + 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (all_dist) begin
            row_q <= '0;
            st_q  <= ST_REGEN;
          end
        end
        default: begin
          if (last_row) begin
            row_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (dist_take) dist_r[cnt_q[CNT_W-2:0]] <= dist_in;
  end

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_flat
    assign dist_flat[g*DIST_W +: DIST_W] = dist_r[g];
  end
endmodule

// File: rtl/depth_skip_pred.sv
module depth_skip_pred
  import dsk_pkg::*;
#(
  parameter int MAX_N    = 64,
  parameter int MIN_N    = 8,
  parameter int SAMPLE_W = 8,
  parameter int RES_W    = 9,
  parameter int DIST_W   = 16,
  localparam int ROW_W   = $clog2(MAX_N),
  localparam int NW      = ROW_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [1:0]                size_sel,
  input  logic [MAX_N*SAMPLE_W-1:0] left_nb,
  input  logic [MAX_N*SAMPLE_W-1:0] above_nb,
  input  logic                      dist_valid,
  input  logic [DIST_W-1:0]         dist_in,
  input  logic [MAX_N*SAMPLE_W-1:0] orig_line,
  output logic                      pred_valid,
  output logic                      pred_regen,
  output logic [1:0]                pred_mode,
  output logic [ROW_W-1:0]          pred_row,
  output logic [MAX_N*SAMPLE_W-1:0] pred_line,
  output logic                      res_valid,
  output logic [MAX_N*RES_W-1:0]    res_line,
  output logic [1:0]                best_mode,
  output logic                      done
);
  logic                      cap_en, emit, regen, last_row, pick_en;
  logic [NW-1:0]             n_q, pred_n_q;
  logic [1:0]                gen_mode, cur_mode, pick;
  logic [ROW_W-1:0]          row_q;
  logic [4*DIST_W-1:0]       dist_flat;
  logic [MAX_N*SAMPLE_W-1:0] left_q, above_q, gen_line;
  logic                      pred_last_q, res_last;

  dsk_ctrl #(.MAX_N(MAX_N), .MIN_N(MIN_N), .DIST_W(DIST_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .dist_valid(dist_valid), .dist_in(dist_in),
    .cap_en(cap_en), .n_q(n_q), .mode_q(gen_mode), .row_q(row_q),
    .emit(emit), .regen(regen), .last_row(last_row), .pick_en(pick_en),
    .dist_flat(dist_flat)
  );

  always_ff @(posedge clk) begin
    if (cap_en) begin
      left_q  <= left_nb;
      above_q <= above_nb;
    end
  end

  assign cur_mode = regen ? best_mode : gen_mode;

  dsk_line_gen #(.MAX_N(MAX_N), .SW(SAMPLE_W)) u_gen (
    .left_q(left_q), .above_q(above_q), .n_sz(n_q),
    .mode(cur_mode), .row(row_q), .line(gen_line)
  );

  dsk_pick #(.DIST_W(DIST_W)) u_pick (
    .dist_flat(dist_flat), .best(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_regen  <= 1'b0;
      pred_mode   <= 2'd0;
      pred_row    <= '0;
      pred_line   <= '0;
      pred_last_q <= 1'b0;
      pred_n_q    <= NW'(MIN_N);
      best_mode   <= 2'd0;
      done        <= 1'b0;
    end else begin
      pred_valid  <= emit;
      pred_regen  <= emit & regen;
      pred_mode   <= cur_mode;
      pred_row    <= row_q;
      pred_line   <= emit ? gen_line : '0;
      pred_last_q <= emit & regen & last_row;
      pred_n_q    <= n_q;
      if (pick_en) best_mode <= pick;
      done        <= res_valid & res_last;
    end
  end

  dsk_residue #(.MAX_N(MAX_N), .SW(SAMPLE_W), .RW(RES_W)) u_res (
    .clk(clk), .rst(rst),
    .in_valid(pred_valid & pred_regen), .in_last(pred_last_q),
    .n_sz(pred_n_q), .pred(pred_line), .orig(orig_line),
    .res_valid(res_valid), .res_last(res_last), .res(res_line)
  );
endmodule

// File: rtl/dsk_chk.sv
module dsk_chk #(
  parameter int MAX_N = 64,
  parameter int SW    = 8,
  parameter int ROW_W = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                pred_valid,
  input logic                pred_regen,
  input logic [1:0]          pred_mode,
  input logic [ROW_W-1:0]    pred_row,
  input logic [MAX_N*SW-1:0] pred_line,
  input logic                res_valid,
  input logic [1:0]          best_mode,
  input logic                done
);
  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_regen && pred_row != '0) |->
      ($past(pred_valid) && pred_row == $past(pred_row) + 1'b1));

  // R2, R4, R5
  flat_rows_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && $past(pred_valid) && pred_mode != 2'd1 &&
     pred_mode == $past(pred_mode) && pred_regen == $past(pred_regen)) |->
      $stable(pred_line));

  // R8
  regen_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_regen) |-> pred_mode == best_mode);

  // R9
  best_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_regen && $past(pred_regen)) |-> $stable(best_mode));

  // R10
  res_align_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(pred_valid && pred_regen));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(res_valid) && !res_valid && !pred_valid));
endmodule

bind depth_skip_pred dsk_chk #(.MAX_N(MAX_N), .SW(SAMPLE_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_regen(pred_regen),
  .pred_mode(pred_mode), .pred_row(pred_row), .pred_line(pred_line),
  .res_valid(res_valid), .best_mode(best_mode), .done(done)
);

// File: tb/depth_skip_pred_bench.sv
module depth_skip_pred_bench;
  localparam int MAX_N = 64;
  localparam int SW    = 8;
  localparam int RW    = 9;
  localparam int DW    = 16;
  localparam int ROW_W = 6;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   start = 1'b0;
  logic [1:0]             size_sel = 2'd0;
  logic [MAX_N*SW-1:0]    left_nb = '0;
  logic [MAX_N*SW-1:0]    above_nb = '0;
  logic                   dist_valid = 1'b0;
  logic [DW-1:0]          dist_in = '0;
  logic [MAX_N*SW-1:0]    orig_line = '0;
  logic                   pred_valid, pred_regen, res_valid, done;
  logic [1:0]             pred_mode, best_mode;
  logic [ROW_W-1:0]       pred_row;
  logic [MAX_N*SW-1:0]    pred_line;
  logic [MAX_N*RW-1:0]    res_line;

  int checks = 0;
  int failures = 0;
  int wd = 0;
  int lft[MAX_N];
  int abv[MAX_N];
  int nn = 8;
  int seed_g = 0;

  always #5 clk = ~clk;

  depth_skip_pred u_depth_skip_pred (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .left_nb(left_nb), .above_nb(above_nb),
    .dist_valid(dist_valid), .dist_in(dist_in), .orig_line(orig_line),
    .pred_valid(pred_valid), .pred_regen(pred_regen), .pred_mode(pred_mode),
    .pred_row(pred_row), .pred_line(pred_line),
    .res_valid(res_valid), .res_line(res_line),
    .best_mode(best_mode), .done(done)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [MAX_N*RW-1:0] act, input logic [MAX_N*RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int samp(int mode, int row, int c);
    case (mode)
      0: return lft[nn/2];
      1: return lft[row];
      2: return abv[nn/2];
      default: return abv[c];
    endcase
  endfunction

  function automatic int ofn(int row, int c);
    return (row * 37 + c * 11 + seed_g * 3) % 256;
  endfunction

  function automatic logic [MAX_N*SW-1:0] mk_line(int mode, int row);
    logic [MAX_N*SW-1:0] v = '0;
    for (int c = 0; c < nn; c++) v[c*SW +: SW] = 8'(samp(mode, row, c));
    return v;
  endfunction

  function automatic logic [MAX_N*SW-1:0] mk_orig(int row);
    logic [MAX_N*SW-1:0] v = '0;
    for (int c = 0; c < MAX_N; c++) v[c*SW +: SW] = 8'(ofn(row, c));
    return v;
  endfunction

  function automatic logic [MAX_N*RW-1:0] mk_res(int mode, int row);
    logic [MAX_N*RW-1:0] v = '0;
    for (int c = 0; c < nn; c++) v[c*RW +: RW] = 9'((ofn(row, c) - samp(mode, row, c)) & 511);
    return v;
  endfunction

  function automatic string mode_req(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_case(input int sz, input int seed, input int d0, input int d1,
                          input int d2, input int d3, input int dly,
                          input bit poke_start, input bit poke_dist);
    int dv[4];
    int eb, ed, last_c, em, er;
    nn = 8 << sz;
    seed_g = seed;
    for (int i = 0; i < MAX_N; i++) begin
      lft[i] = (seed * 7 + i * 13 + 1) % 256;
      abv[i] = (seed * 5 + i * 29 + 3) % 256;
      left_nb[i*SW +: SW]  = 8'(lft[i]);
      above_nb[i*SW +: SW] = 8'(abv[i]);
    end
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    eb = 0;
    for (int m = 1; m < 4; m++) if (dv[m] < dv[eb]) eb = m;
    ed = 4 * nn + 1 + dly;
    last_c = ed + 3 + nn;

    @(negedge clk);
    start = 1'b1;
    size_sel = 2'(sz);
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= last_c; c++) begin
      @(negedge clk);
      start = 1'b0;
      dist_valid = 1'b0;
      if (c >= 1 && c <= 4 * nn) begin
        em = (c - 1) / nn;
        er = (c - 1) % nn;
        chk("R6", "pred_valid", pred_valid, 1);
        chk("R6", "pred_regen", pred_regen, 0);
        chk("R6", "pred_mode", pred_mode, em);
        chk("R1", "pred_row", pred_row, er);
        chk(mode_req(em), "candidate line", pred_line, mk_line(em, er));
        if (nn < MAX_N) chk("R11", "pred upper lanes", pred_line >> (nn * SW), 0);
      end else if (c >= ed + 2 && c <= ed + 1 + nn) begin
        er = c - ed - 2;
        chk("R9", "regen valid", pred_valid, 1);
        chk("R9", "regen flag", pred_regen, 1);
        chk("R8", "best_mode", best_mode, eb);
        chk("R9", "regen row", pred_row, er);
        chk("R9", "regen line", pred_line, mk_line(eb, er));
        orig_line = mk_orig(er);
      end else begin
        chk("R6", "pred_valid idle", pred_valid, 0);
      end
      if (c >= ed + 3 && c <= ed + 2 + nn) begin
        er = c - ed - 3;
        chk("R10", "res_valid", res_valid, 1);
        chk("R10", "res_line", res_line, mk_res(eb, er));
        if (nn < MAX_N) chk("R11", "res upper lanes", res_line >> (nn * RW), 0);
      end else begin
        chk("R10", "res_valid idle", res_valid, 0);
      end
      chk("R12", "done", done, (c == ed + 3 + nn) ? 1 : 0);
      for (int m = 0; m < 3; m++) begin
        if (c == (m + 1) * nn) begin
          dist_valid = 1'b1;
          dist_in = 16'(dv[m]);
        end
      end
      if (c == 4 * nn + dly) begin
        dist_valid = 1'b1;
        dist_in = 16'(d3);
      end
      // R7: an extra low distortion after all four must not change the choice
      if (poke_dist && c == ed + 2) begin
        dist_valid = 1'b1;
        dist_in = 16'd0;
      end
      // R13: a start during the run must be ignored
      if (poke_start && c == 3) begin
        start = 1'b1;
        size_sel = ~size_sel;
      end
    end
    @(negedge clk);
    dist_valid = 1'b0;
    chk("R7", "best_mode after run", best_mode, eb);
    chk("R12", "done is a single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14", "pred_valid", pred_valid, 0);
    chk("R14", "res_valid", res_valid, 0);
    chk("R14", "done", done, 0);
    chk("R14", "best_mode", best_mode, 0);
    chk("R14", "pred_line", pred_line, 0);
    // R1 R8: 8x8, column-copy wins
    run_case(0, 1, 50, 40, 30, 20, 0, 1'b0, 1'b0);
    // R8 R13: 16x16, all equal so mode 0 wins; start poked mid-run
    run_case(1, 2, 100, 100, 100, 100, 5, 1'b1, 1'b0);
    // R7 R8: 32x32, tie between modes 1 and 3, extra distortion ignored
    run_case(2, 3, 9, 3, 7, 3, 2, 1'b0, 1'b1);
    // R1 R8: 64x64, tie between modes 2 and 3
    run_case(3, 4, 500, 600, 200, 200, 1, 1'b0, 1'b0);
    // R2 R9: 8x8, flat-left wins after a late fourth distortion
    run_case(0, 5, 10, 20, 30, 40, 3, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule